// File: doc/BRIEF.md
# Register-Interfaced Word Memory

This block is a small word-addressed RAM that a processor sequencer can reach only through two holding registers. One is an address register and one is a data register. A fetch/store select chooses the operation. The processor loads the address register, and for a store it also loads the data register. It then raises `start` together with the operation select. An internal controller walks the operation through its steps. It decodes the address into a registered one-hot row select, then moves one whole cell either from the array into the data register (fetch) or from the data register into the array (store). It marks the end with a single-cycle `done` pulse.

Every operation takes the same number of cycles, whichever cell it addresses. While an operation is in flight, the block ignores new `start` requests and register loads. This protects the address and data the operation is using. The storage is an internal register array of `2**ADDR_W` cells, each `DATA_W` bits wide.

Top module: `regmem_unit`

## Requirements
- R1: The memory holds 2**ADDR_W cells of DATA_W bits each, addressed 0 to 2**ADDR_W-1. A whole cell is the smallest unit read or written, and the lowest and highest addresses are independent cells.
- R2: A fetch copies the addressed cell into the data register (`mdr_q`) and leaves the cell unchanged, so a repeated fetch returns the same value.
- R3: A store overwrites the addressed cell with the data register contents and leaves `mdr_q` unchanged.
- R4: `fs` is sampled in the cycle `start` is accepted: `fs`=1 selects a store and `fs`=0 selects a fetch.
- R5: The address register (`mar_q`) loads `mar_in` when `mar_ld`=1, and the data register loads `mdr_in` when `mdr_ld`=1. The two loads are independent and may happen in separate cycles.
- R6: `done` rises exactly 3 clock cycles after the edge that accepts `start`, for every address and both operations.
- R7: `done` is high for exactly one cycle. `busy` is high from the cycle after acceptance through the `done` cycle, and low afterwards.
- R8: A `start` raised while `busy`=1 is ignored and produces no extra operation or `done` pulse.
- R9: `mar_ld` and `mdr_ld` are ignored while `busy`=1.
- R10: After reset, `mar_q`=0, `mdr_q`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mar_ld | input | 1 | Load enable for the address register |
| mar_in | input | ADDR_W | New address value |
| mdr_ld | input | 1 | Load enable for the data register |
| mdr_in | input | DATA_W | New data value |
| fs | input | 1 | Operation select: 1 store, 0 fetch |
| start | input | 1 | Begin an operation when idle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mar_q | output | ADDR_W | Address register contents |
| mdr_q | output | DATA_W | Data register contents |

## Verification
The assertions assume that all inputs change synchronously to `clk`. They also assume that `start` is not raised during the two cycles in which the internal reset release is still settling. A fetch is taken to be meaningful only on a cell that has already been written, because the array itself has no reset. The stimulus waits several cycles after reset before its first request and always stores a cell before fetching it. It deliberately drives `start`, `mar_ld` and `mdr_ld` during busy cycles to exercise the ignore rules.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEC  = 2'd1,
    ST_XFER = 2'd2,
    ST_FIN  = 2'd3
  } mem_state_e;
endpackage

// File: rtl/regmem_ctrl.sv
module regmem_ctrl
  import regmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fs,
  output logic busy,
  output logic done,
  output logic dec_en,
  output logic rd_xfer,
  output logic wr_xfer
);
  mem_state_e state_q, state_d;
  logic       op_store_q;
  logic       accept;

  assign accept = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_DEC;
      ST_DEC:  state_d = ST_XFER;
      ST_XFER: state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_store_q <= fs;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FIN);
  assign dec_en  = (state_q == ST_DEC);
  assign rd_xfer = (state_q == ST_XFER) && !op_store_q;
  assign wr_xfer = (state_q == ST_XFER) &&  op_store_q;
endmodule

// File: rtl/regmem_regs.sv
module regmem_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              mar_ld,
  input  logic [ADDR_W-1:0] mar_in,
  input  logic              mdr_ld,
  input  logic [DATA_W-1:0] mdr_in,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q
);
  logic              mar_en, mdr_en;
  logic [DATA_W-1:0] mdr_d;

  assign mar_en = mar_ld && !busy;
  assign mdr_en = (mdr_ld && !busy) || cap_en;
  assign mdr_d  = cap_en ? cap_data : mdr_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (mar_en) mar_q <= mar_in;
      if (mdr_en) mdr_q <= mdr_d;
    end
  end
endmodule

// File: rtl/regmem_array.sv
module regmem_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int CELLS = 1 << ADDR_W;

  logic [CELLS-1:0]  sel_q;
  logic [CELLS-1:0]  sel_d;
  logic [DATA_W-1:0] mem [CELLS];

  always_comb begin
    sel_d = '0;
    sel_d[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (dec_en) sel_q <= sel_d;
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (wr_en && sel_q[i]) mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < CELLS; i++) begin
      rdata = rdata | (mem[i] & {DATA_W{sel_q[i]}});
    end
  end
endmodule

// File: rtl/regmem_unit.sv
module regmem_unit #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_ld,
  input  logic [ADDR_W-1:0] mar_in,
  input  logic              mdr_ld,
  input  logic [DATA_W-1:0] mdr_in,
  input  logic              fs,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              dec_en, rd_xfer, wr_xfer;
  logic [DATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  regmem_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (start),
    .fs      (fs),
    .busy    (busy),
    .done    (done),
    .dec_en  (dec_en),
    .rd_xfer (rd_xfer),
    .wr_xfer (wr_xfer)
  );

  regmem_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .busy     (busy),
    .mar_ld   (mar_ld),
    .mar_in   (mar_in),
    .mdr_ld   (mdr_ld),
    .mdr_in   (mdr_in),
    .cap_en   (rd_xfer),
    .cap_data (rd_data),
    .mar_q    (mar_q),
    .mdr_q    (mdr_q)
  );

  regmem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .dec_en (dec_en),
    .addr   (mar_q),
    .wr_en  (wr_xfer),
    .wdata  (mdr_q),
    .rdata  (rd_data)
  );
endmodule

// File: rtl/regmem_chk.sv
module regmem_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mar_q
);
  // R6
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start && !busy, 3));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mar_q));

  // R8
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

bind regmem_unit regmem_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .mar_q (mar_q)
);

// File: tb/regmem_unit_tb.sv
`timescale 1ns/1ps
module regmem_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mar_ld, mdr_ld, fs, start;
  logic [3:0] mar_in;
  logic [7:0] mdr_in;
  logic       busy, done;
  logic [3:0] mar_q;
  logic [7:0] mdr_q;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  regmem_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mar_ld(mar_ld), .mar_in(mar_in),
    .mdr_ld(mdr_ld), .mdr_in(mdr_in), .fs(fs), .start(start),
    .busy(busy), .done(done), .mar_q(mar_q), .mdr_q(mdr_q)
  );

  // {store, addr, data, expected mdr_q after op}
  localparam logic [20:0] VEC [11] = '{
    {1'b1, 4'd0,  8'hA5, 8'hA5},
    {1'b1, 4'd15, 8'h3C, 8'h3C},
    {1'b1, 4'd7,  8'h81, 8'h81},
    {1'b0, 4'd0,  8'h00, 8'hA5},
    {1'b0, 4'd15, 8'h00, 8'h3C},
    {1'b1, 4'd7,  8'hFF, 8'hFF},
    {1'b0, 4'd7,  8'h00, 8'hFF},
    {1'b0, 4'd7,  8'h00, 8'hFF},
    {1'b1, 4'd1,  8'h00, 8'h00},
    {1'b0, 4'd1,  8'h00, 8'h00},
    {1'b0, 4'd0,  8'h00, 8'hA5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic st, input logic [3:0] a, input logic [7:0] d,
                       input bit intrude, output int lat);
    @(negedge clk); mar_ld = 1'b1; mar_in = a;
    @(negedge clk); mar_ld = 1'b0;
    if (st) begin mdr_ld = 1'b1; mdr_in = d; end
    @(negedge clk); mdr_ld = 1'b0; start = 1'b1; fs = st;
    lat = 0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (c == 1) begin
        if (intrude) begin
          fs = ~st; mar_ld = 1'b1; mar_in = 4'd9; mdr_ld = 1'b1; mdr_in = 8'h77;
        end else begin
          start = 1'b0;
        end
      end
      if (done) begin lat = c; break; end
    end
    @(negedge clk);
    chk("R7 done single cycle", {31'd0, done}, 32'd0);
    chk("R7 busy low after done", {31'd0, busy}, 32'd0);
    start = 1'b0; mar_ld = 1'b0; mdr_ld = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; mar_ld = 0; mdr_ld = 0; fs = 0; start = 0; mar_in = 0; mdr_in = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 mar_q", {28'd0, mar_q}, 32'd0);
    chk("R10 mdr_q", {24'd0, mdr_q}, 32'd0);
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R6
    foreach (VEC[i]) begin
      do_op(VEC[i][20], VEC[i][19:16], VEC[i][15:8], 1'b0, lat);
      chk("R6 latency", lat, 32'd3);
      chk(VEC[i][20] ? "R3 mdr after store" : "R2 R1 fetched value",
          {24'd0, mdr_q}, {24'd0, VEC[i][7:0]});
      chk("R4 R5 mar kept", {28'd0, mar_q}, {28'd0, VEC[i][19:16]});
    end

    // R5: separate loads
    @(negedge clk); mar_ld = 1'b1; mar_in = 4'd6;
    @(negedge clk); mar_ld = 1'b0;
    chk("R5 mar load alone", {28'd0, mar_q}, 32'd6);
    chk("R5 mdr untouched", {24'd0, mdr_q}, 32'hA5);
    @(negedge clk); mdr_ld = 1'b1; mdr_in = 8'h5A;
    @(negedge clk); mdr_ld = 1'b0;
    chk("R5 mdr load alone", {24'd0, mdr_q}, 32'h5A);
    chk("R5 mar untouched", {28'd0, mar_q}, 32'd6);

    // Prepare cell 9 with a known value
    do_op(1'b1, 4'd9, 8'h42, 1'b0, lat);
    // R8 R9: fetch cell 7 with start/loads/fs flipped during busy
    do_op(1'b0, 4'd7, 8'h00, 1'b1, lat);
    chk("R8 one done only", lat, 32'd3);
    chk("R9 mar ignored while busy", {28'd0, mar_q}, 32'd7);
    chk("R9 mdr keeps fetched value", {24'd0, mdr_q}, 32'hFF);
    repeat (4) @(negedge clk);
    chk("R8 no extra done", {31'd0, done}, 32'd0);
    chk("R8 no extra busy", {31'd0, busy}, 32'd0);
    do_op(1'b0, 4'd9, 8'h00, 1'b0, lat);
    chk("R8 R9 cell 9 not overwritten", {24'd0, mdr_q}, 32'h42);
    do_op(1'b0, 4'd7, 8'h00, 1'b0, lat);
    chk("R2 cell 7 unchanged", {24'd0, mdr_q}, 32'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule